// File: doc/BRIEF.md
# Capture/Compare Timer Flag Register Unit

This block keeps the event flags of a 16-bit capture/compare timer and raises its interrupt requests. Six channel flags and one counter-wrap flag are set by single-cycle event pulses from the surrounding timer. They are visible through a byte-wide register bus. Software normally clears a flag by writing a one to its bit position in one of two flag registers.

A fast-clear option lets software skip that extra write. With fast-clear enabled, the data access that services an event also clears its flag. For a channel in capture mode this is a read of its data bytes. For a channel in compare mode it is a write of its data bytes. Any read or write of the counter bytes clears the wrap flag. The counter, the capture/compare datapaths and the pins stay outside the block. They reach it only as event pulses, mode bits and enables.

Top module: `tmr_flag_unit`

## Requirements
- R1: After reset all seven flags are zero and both interrupt outputs are low.
- R2: A one on `ch_event[i]` sets the flag of channel i+2 at the next clock edge. No flag ever sets without an event.
- R3: A one on `ovf_pulse` (the counter wrapping from 0xFFFF to 0x0000) sets the wrap flag at the next clock edge.
- R4: A write to offset 0x0E clears every channel flag whose bit is one in the write data. Bit 7 maps to channel 7, down to bit 2 for channel 2. Zero bits and bits 1:0 leave the flags unchanged.
- R5: A write to offset 0x0F with bit 7 set clears the wrap flag. The other data bits have no effect.
- R6: A read of 0x0E returns the channel flags in bits 7:2 and zero in bits 1:0. A read of 0x0F returns the wrap flag in bit 7 and zero elsewhere. Reads of any other offset return zero from this block. Reads clear nothing unless fast-clear applies.
- R7: With fast-clear enabled and channel k in capture mode (`ch_is_cmp` bit low), a read of offset 0x10+2k or 0x11+2k clears flag k. A write to those offsets does not.
- R8: With fast-clear enabled and channel k in compare mode (`ch_is_cmp` bit high), a write of offset 0x10+2k or 0x11+2k clears flag k. A read does not.
- R9: With fast-clear enabled, a read or write of offset 0x04 or 0x05 clears the wrap flag. Access to other offsets does not.
- R10: With fast-clear disabled, data and counter accesses clear nothing. Accesses to offsets 0x10 to 0x13 (channels 0 and 1) never clear a flag.
- R11: When a set event and any clear meet in the same cycle, the flag ends at one.
- R12: Each interrupt output is its flag ANDed with its enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Register byte offset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational, zero when not reading a flag register |
| ch_event | input | 6 | Capture/compare event pulses, bit i for channel i+2 |
| ovf_pulse | input | 1 | Counter wrap pulse |
| ch_is_cmp | input | 6 | Per-channel mode: 1 compare, 0 capture |
| fast_clr_en | input | 1 | Enables clearing as a side effect of data access |
| ch_irq_en | input | 6 | Channel interrupt enables |
| ovf_irq_en | input | 1 | Wrap interrupt enable |
| ch_irq | output | 6 | Channel interrupt requests |
| ovf_irq | output | 1 | Wrap interrupt request |

## Verification
Every cycle, the assertions check several things. A pulse always lands in its flag, even against a clear (set priority). A flag never rises without an event. A one written to the channel flag register leaves no flag standing unless an event came with it. With fast-clear off, only flag-register writes can drop a flag. They also check the reserved read bits and the interrupt masking. Other behaviour is shown only by the bench's sequences: that the right channel reacts to each address pair, that the clear depends on the access direction and the mode bit, that the channel 0 and 1 pairs clear nothing, and that the counter offsets clear the wrap flag.

// File: rtl/tfu_pkg.sv
package tfu_pkg;
   localparam int TFU_ADDR_W  = 5;
   localparam int TFU_DATA_W  = 8;
   localparam int TFU_NUM_CH  = 6;
   localparam int TFU_CH_LO   = 2;

   // Byte offsets of the register windows this block decodes
   localparam int TFU_FLAG1_OFS = 'h0E;
   localparam int TFU_FLAG2_OFS = 'h0F;
   localparam int TFU_CNT_OFS   = 'h04;
   localparam int TFU_CHDAT_OFS = 'h10;
   localparam int TFU_OVF_BIT   = 7;

   // Half-address (byte pair index) owned by a given implemented channel
   function automatic int tfu_pair_idx(int base, int lo, int idx);
      return base / 2 + lo + idx;
   endfunction
endpackage

// File: rtl/tfu_decode.sv
module tfu_decode
   import tfu_pkg::*;
#(
   parameter int ADDR_W    = TFU_ADDR_W,
   parameter int DATA_W    = TFU_DATA_W,
   parameter int NUM_CH    = TFU_NUM_CH,
   parameter int CH_LO     = TFU_CH_LO,
   parameter int FLAG1_OFS = TFU_FLAG1_OFS,
   parameter int FLAG2_OFS = TFU_FLAG2_OFS,
   parameter int CNT_OFS   = TFU_CNT_OFS,
   parameter int CHDAT_OFS = TFU_CHDAT_OFS,
   parameter int OVF_BIT   = TFU_OVF_BIT
) (
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              fast_clr_en,
   input  logic [NUM_CH-1:0] ch_is_cmp,
   output logic [NUM_CH-1:0] ch_clr,
   output logic              ovf_clr
);
   localparam logic [ADDR_W-1:0] F1_A  = ADDR_W'(FLAG1_OFS);
   localparam logic [ADDR_W-1:0] F2_A  = ADDR_W'(FLAG2_OFS);
   localparam logic [ADDR_W-2:0] CNT_P = (ADDR_W-1)'(CNT_OFS / 2);

   logic              f1_wr, f2_wr, any_acc;
   logic [ADDR_W-2:0] pair_a;
   logic              unused_wd;

   assign f1_wr     = bus_wr && (bus_addr == F1_A);
   assign f2_wr     = bus_wr && (bus_addr == F2_A);
   assign any_acc   = bus_rd || bus_wr;
   assign pair_a    = bus_addr[ADDR_W-1:1];
   assign unused_wd = ^bus_wdata;

   assign ovf_clr = (f2_wr && bus_wdata[OVF_BIT]) ||
                    (fast_clr_en && any_acc && (pair_a == CNT_P));

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      localparam logic [ADDR_W-2:0] MY_P =
         (ADDR_W-1)'(tfu_pair_idx(CHDAT_OFS, CH_LO, i));
      logic hit, dir_ok;
      assign hit      = (pair_a == MY_P);
      assign dir_ok   = ch_is_cmp[i] ? bus_wr : bus_rd;
      assign ch_clr[i] = (f1_wr && bus_wdata[CH_LO+i]) ||
                         (fast_clr_en && hit && dir_ok);
   end
endmodule

// File: rtl/tfu_flag.sv
module tfu_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= 1'b0;
      else if (set_i) q <= 1'b1;
      else if (clr_i) q <= 1'b0;
   end
endmodule

// File: rtl/tfu_rdmux.sv
module tfu_rdmux
   import tfu_pkg::*;
#(
   parameter int ADDR_W    = TFU_ADDR_W,
   parameter int DATA_W    = TFU_DATA_W,
   parameter int NUM_CH    = TFU_NUM_CH,
   parameter int CH_LO     = TFU_CH_LO,
   parameter int FLAG1_OFS = TFU_FLAG1_OFS,
   parameter int FLAG2_OFS = TFU_FLAG2_OFS,
   parameter int OVF_BIT   = TFU_OVF_BIT
) (
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   input  logic [NUM_CH-1:0] ch_flag,
   input  logic              ovf_flag,
   output logic [DATA_W-1:0] bus_rdata
);
   localparam logic [ADDR_W-1:0] F1_A = ADDR_W'(FLAG1_OFS);
   localparam logic [ADDR_W-1:0] F2_A = ADDR_W'(FLAG2_OFS);

   always_comb begin
      bus_rdata = '0;
      if (bus_rd && (bus_addr == F1_A)) bus_rdata[CH_LO +: NUM_CH] = ch_flag;
      if (bus_rd && (bus_addr == F2_A)) bus_rdata[OVF_BIT] = ovf_flag;
   end
endmodule

// File: rtl/tmr_flag_unit.sv
module tmr_flag_unit
   import tfu_pkg::*;
#(
   parameter int ADDR_W    = TFU_ADDR_W,
   parameter int DATA_W    = TFU_DATA_W,
   parameter int NUM_CH    = TFU_NUM_CH,
   parameter int CH_LO     = TFU_CH_LO,
   parameter int FLAG1_OFS = TFU_FLAG1_OFS,
   parameter int FLAG2_OFS = TFU_FLAG2_OFS,
   parameter int CNT_OFS   = TFU_CNT_OFS,
   parameter int CHDAT_OFS = TFU_CHDAT_OFS,
   parameter int OVF_BIT   = TFU_OVF_BIT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [NUM_CH-1:0] ch_event,
   input  logic              ovf_pulse,
   input  logic [NUM_CH-1:0] ch_is_cmp,
   input  logic              fast_clr_en,
   input  logic [NUM_CH-1:0] ch_irq_en,
   input  logic              ovf_irq_en,
   output logic [NUM_CH-1:0] ch_irq,
   output logic              ovf_irq
);
   localparam int TOP_PAIR = tfu_pair_idx(CHDAT_OFS, CH_LO, NUM_CH - 1);

   // Elaboration-time parameter checks
   if (CH_LO + NUM_CH > DATA_W) begin : g_bad_width
      $error("channel flags do not fit the data byte");
   end
   if (OVF_BIT >= DATA_W) begin : g_bad_ovf
      $error("wrap flag bit outside the data byte");
   end
   if (TOP_PAIR >= (1 << (ADDR_W - 1))) begin : g_bad_window
      $error("channel data window exceeds the address space");
   end
   if ((CNT_OFS % 2 != 0) || (CHDAT_OFS % 2 != 0)) begin : g_bad_align
      $error("counter and data windows must be pair aligned");
   end

   logic [NUM_CH-1:0] ch_clr, ch_flag;
   logic              ovf_clr, ovf_flag;

   tfu_decode #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CH(NUM_CH), .CH_LO(CH_LO),
      .FLAG1_OFS(FLAG1_OFS), .FLAG2_OFS(FLAG2_OFS), .CNT_OFS(CNT_OFS),
      .CHDAT_OFS(CHDAT_OFS), .OVF_BIT(OVF_BIT)
   ) u_dec (
      .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .fast_clr_en(fast_clr_en),
      .ch_is_cmp(ch_is_cmp), .ch_clr(ch_clr), .ovf_clr(ovf_clr)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_chf
      tfu_flag u_f (
         .clk(clk), .rst_n(rst_n), .set_i(ch_event[i]),
         .clr_i(ch_clr[i]), .q(ch_flag[i])
      );
   end

   tfu_flag u_ovf (
      .clk(clk), .rst_n(rst_n), .set_i(ovf_pulse),
      .clr_i(ovf_clr), .q(ovf_flag)
   );

   tfu_rdmux #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CH(NUM_CH), .CH_LO(CH_LO),
      .FLAG1_OFS(FLAG1_OFS), .FLAG2_OFS(FLAG2_OFS), .OVF_BIT(OVF_BIT)
   ) u_rd (
      .bus_addr(bus_addr), .bus_rd(bus_rd), .ch_flag(ch_flag),
      .ovf_flag(ovf_flag), .bus_rdata(bus_rdata)
   );

   assign ch_irq  = ch_flag & ch_irq_en;
   assign ovf_irq = ovf_flag & ovf_irq_en;
endmodule

// File: rtl/tfu_chk.sv
module tfu_chk
   import tfu_pkg::*;
#(
   parameter int ADDR_W    = TFU_ADDR_W,
   parameter int DATA_W    = TFU_DATA_W,
   parameter int NUM_CH    = TFU_NUM_CH,
   parameter int CH_LO     = TFU_CH_LO,
   parameter int FLAG1_OFS = TFU_FLAG1_OFS,
   parameter int FLAG2_OFS = TFU_FLAG2_OFS,
   parameter int OVF_BIT   = TFU_OVF_BIT
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_rd,
   input logic              bus_wr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic [NUM_CH-1:0] ch_event,
   input logic              ovf_pulse,
   input logic              fast_clr_en,
   input logic [NUM_CH-1:0] ch_irq_en,
   input logic              ovf_irq_en,
   input logic [NUM_CH-1:0] ch_irq,
   input logic              ovf_irq,
   input logic [NUM_CH-1:0] ch_flag,
   input logic              ovf_flag
);
   localparam logic [ADDR_W-1:0] F1_A = ADDR_W'(FLAG1_OFS);
   localparam logic [ADDR_W-1:0] F2_A = ADDR_W'(FLAG2_OFS);
   localparam logic [DATA_W-1:0] OVF_MASK = DATA_W'(1) << OVF_BIT;

   AST_CH_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (|ch_event) |=> ((ch_flag & $past(ch_event)) == $past(ch_event))); // R11

   AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (|(~ch_flag)) |=> ((ch_flag & ~$past(ch_flag) & ~$past(ch_event)) == '0)); // R2

   AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_pulse |=> ovf_flag); // R3

   AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == F1_A) |=>
      ((ch_flag & $past(bus_wdata[CH_LO +: NUM_CH]) & ~$past(ch_event)) == '0)); // R4

   AST_NO_FALL_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!fast_clr_en && !(bus_wr && (bus_addr == F1_A || bus_addr == F2_A))) |=>
      ((($past(ch_flag) & ~ch_flag) == '0) && !($past(ovf_flag) && !ovf_flag))); // R10

   AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == F2_A) |-> ((bus_rdata & ~OVF_MASK) == '0)); // R6

   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (((ch_irq & ~ch_irq_en) == '0) && !(ovf_irq && !ovf_irq_en))); // R12
endmodule

bind tmr_flag_unit tfu_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CH(NUM_CH), .CH_LO(CH_LO),
   .FLAG1_OFS(FLAG1_OFS), .FLAG2_OFS(FLAG2_OFS), .OVF_BIT(OVF_BIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
   .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
   .ch_event(ch_event), .ovf_pulse(ovf_pulse), .fast_clr_en(fast_clr_en),
   .ch_irq_en(ch_irq_en), .ovf_irq_en(ovf_irq_en), .ch_irq(ch_irq),
   .ovf_irq(ovf_irq), .ch_flag(ch_flag), .ovf_flag(ovf_flag)
);

// File: tb/tmr_flag_unit_tb.sv
module tmr_flag_unit_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] bus_addr = '0;
   logic       bus_rd = 1'b0, bus_wr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [5:0] ch_event = '0;
   logic       ovf_pulse = 1'b0;
   logic [5:0] ch_is_cmp = '0;
   logic       fast_clr_en = 1'b0;
   logic [5:0] ch_irq_en = '1;
   logic       ovf_irq_en = 1'b1;
   logic [5:0] ch_irq;
   logic       ovf_irq;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #4 clk = ~clk;

   tmr_flag_unit u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ch_event(ch_event), .ovf_pulse(ovf_pulse), .ch_is_cmp(ch_is_cmp),
      .fast_clr_en(fast_clr_en), .ch_irq_en(ch_irq_en),
      .ovf_irq_en(ovf_irq_en), .ch_irq(ch_irq), .ovf_irq(ovf_irq)
   );

   typedef struct packed {
      logic [3:0] req;
      logic [5:0] ev;
      logic       ovf;
      logic       rd;
      logic       wr;
      logic [4:0] addr;
      logic [7:0] wd;
      logic [5:0] cmp;
      logic       fc;
      logic [5:0] exp_ch;
      logic       exp_ovf;
   } vec_t;

   localparam int NV = 27;
   localparam vec_t VEC [NV] = '{
      '{4'd2,  6'h3F, 1'b0, 1'b0, 1'b0, 5'h00, 8'h00, 6'h00, 1'b0, 6'h3F, 1'b0}, // R2
      '{4'd4,  6'h00, 1'b0, 1'b0, 1'b1, 5'h0E, 8'h0C, 6'h00, 1'b0, 6'h3C, 1'b0}, // R4
      '{4'd4,  6'h00, 1'b0, 1'b0, 1'b1, 5'h0E, 8'h00, 6'h00, 1'b0, 6'h3C, 1'b0}, // R4 zeros
      '{4'd4,  6'h00, 1'b0, 1'b0, 1'b1, 5'h0E, 8'h03, 6'h00, 1'b0, 6'h3C, 1'b0}, // R4 low bits
      '{4'd3,  6'h00, 1'b1, 1'b0, 1'b0, 5'h00, 8'h00, 6'h00, 1'b0, 6'h3C, 1'b1}, // R3
      '{4'd5,  6'h00, 1'b0, 1'b0, 1'b1, 5'h0F, 8'h7F, 6'h00, 1'b0, 6'h3C, 1'b1}, // R5
      '{4'd5,  6'h00, 1'b0, 1'b0, 1'b1, 5'h0F, 8'h80, 6'h00, 1'b0, 6'h3C, 1'b0}, // R5
      '{4'd3,  6'h00, 1'b1, 1'b0, 1'b0, 5'h00, 8'h00, 6'h00, 1'b0, 6'h3C, 1'b1}, // R3
      '{4'd10, 6'h00, 1'b0, 1'b1, 1'b0, 5'h04, 8'h00, 6'h00, 1'b0, 6'h3C, 1'b1}, // R10
      '{4'd9,  6'h00, 1'b0, 1'b1, 1'b0, 5'h05, 8'h00, 6'h00, 1'b1, 6'h3C, 1'b0}, // R9
      '{4'd3,  6'h00, 1'b1, 1'b0, 1'b0, 5'h00, 8'h00, 6'h00, 1'b0, 6'h3C, 1'b1}, // R3
      '{4'd9,  6'h00, 1'b0, 1'b0, 1'b1, 5'h04, 8'h55, 6'h00, 1'b1, 6'h3C, 1'b0}, // R9
      '{4'd7,  6'h00, 1'b0, 1'b1, 1'b0, 5'h18, 8'h00, 6'h00, 1'b1, 6'h38, 1'b0}, // R7
      '{4'd7,  6'h00, 1'b0, 1'b0, 1'b1, 5'h1B, 8'hAA, 6'h00, 1'b1, 6'h38, 1'b0}, // R7 wr
      '{4'd7,  6'h00, 1'b0, 1'b1, 1'b0, 5'h1B, 8'h00, 6'h00, 1'b1, 6'h30, 1'b0}, // R7
      '{4'd8,  6'h00, 1'b0, 1'b1, 1'b0, 5'h1E, 8'h00, 6'h20, 1'b1, 6'h30, 1'b0}, // R8 rd
      '{4'd8,  6'h00, 1'b0, 1'b0, 1'b1, 5'h1F, 8'h12, 6'h20, 1'b1, 6'h10, 1'b0}, // R8
      '{4'd2,  6'h3F, 1'b0, 1'b0, 1'b0, 5'h00, 8'h00, 6'h00, 1'b0, 6'h3F, 1'b0}, // R2
      '{4'd10, 6'h00, 1'b0, 1'b1, 1'b0, 5'h10, 8'h00, 6'h00, 1'b1, 6'h3F, 1'b0}, // R10
      '{4'd10, 6'h00, 1'b0, 1'b0, 1'b1, 5'h13, 8'h00, 6'h3F, 1'b1, 6'h3F, 1'b0}, // R10
      '{4'd7,  6'h00, 1'b0, 1'b1, 1'b0, 5'h14, 8'h00, 6'h00, 1'b1, 6'h3E, 1'b0}, // R7
      '{4'd10, 6'h00, 1'b0, 1'b1, 1'b0, 5'h16, 8'h00, 6'h00, 1'b0, 6'h3E, 1'b0}, // R10
      '{4'd11, 6'h02, 1'b0, 1'b0, 1'b1, 5'h0E, 8'hFF, 6'h00, 1'b0, 6'h02, 1'b0}, // R11
      '{4'd11, 6'h00, 1'b1, 1'b0, 1'b1, 5'h0F, 8'h80, 6'h00, 1'b0, 6'h02, 1'b1}, // R11
      '{4'd11, 6'h00, 1'b1, 1'b1, 1'b0, 5'h04, 8'h00, 6'h00, 1'b1, 6'h02, 1'b1}, // R11
      '{4'd9,  6'h00, 1'b0, 1'b1, 1'b0, 5'h06, 8'h00, 6'h00, 1'b1, 6'h02, 1'b1}, // R9
      '{4'd11, 6'h01, 1'b0, 1'b1, 1'b0, 5'h14, 8'h00, 6'h00, 1'b1, 6'h03, 1'b1}  // R11
   };

   task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic idle();
      bus_rd = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
      ch_event = '0; ovf_pulse = 1'b0; fast_clr_en = 1'b0;
   endtask

   // Read inside the low clock phase so no edge sees the strobe
   task automatic peek(logic [4:0] a, logic [7:0] exp, string tag);
      @(negedge clk);
      idle();
      bus_addr = a; bus_rd = 1'b1;
      #1 check(tag, bus_rdata, exp);
      #1 bus_rd = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 ch_irq", {2'b0, ch_irq}, 8'h00);
      check("R1 ovf_irq", {7'b0, ovf_irq}, 8'h00);
      rst_n = 1'b1;
      peek(5'h0E, 8'h00, "R1 flag1 read");
      peek(5'h0F, 8'h00, "R1 flag2 read");

      foreach (VEC[k]) begin
         @(negedge clk);
         bus_rd = VEC[k].rd; bus_wr = VEC[k].wr; bus_addr = VEC[k].addr;
         bus_wdata = VEC[k].wd; ch_event = VEC[k].ev; ovf_pulse = VEC[k].ovf;
         ch_is_cmp = VEC[k].cmp; fast_clr_en = VEC[k].fc;
         @(negedge clk);
         check($sformatf("R%0d vec %0d ch", VEC[k].req, k), {2'b0, ch_irq},
               {2'b0, VEC[k].exp_ch});
         check($sformatf("R%0d vec %0d ovf", VEC[k].req, k), {7'b0, ovf_irq},
               {7'b0, VEC[k].exp_ovf});
         idle();
      end

      // Flags now 03 / wrap 1: read-back layout
      peek(5'h0E, 8'h0C, "R6 flag1 layout");
      peek(5'h0F, 8'h80, "R6 flag2 layout");
      peek(5'h05, 8'h00, "R6 other offset");
      // R6: plain reads with fast-clear off leave flags intact
      peek(5'h0E, 8'h0C, "R6 read no side effect");

      // R12: gating by enables
      @(negedge clk);
      ch_irq_en = 6'b000010; ovf_irq_en = 1'b0;
      #1 check("R12 ch gate", {2'b0, ch_irq}, 8'h02);
      check("R12 ovf gate", {7'b0, ovf_irq}, 8'h00);
      ch_irq_en = 6'b111100;
      #1 check("R12 ch gate none", {2'b0, ch_irq}, 8'h00);
      ch_irq_en = '1; ovf_irq_en = 1'b1;

      // R1: reset clears raised flags
      @(negedge clk);
      rst_n = 1'b0;
      #1 check("R1 async clear", {1'b0, ovf_irq, ch_irq}, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule